// File: doc/BRIEF.md
# Saturating-Counter Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of small up/down counters that saturate at both ends. Each counter learns the recent behaviour of the branches whose addresses map onto it. The fetch stage presents a branch address on the lookup port and gets a taken or not-taken guess back in the same cycle, together with the raw counter value. When the branch resolves later in the pipeline, the update port carries the same address and the real outcome, and the selected counter moves one step toward that outcome on the next clock edge.

The table is addressed directly by a slice of the address just above the instruction word offset. There is no tag, so branches whose addresses differ only in higher bits share one counter. The counter width is a parameter. A width of one gives a last-outcome predictor, and a width of two or more gives hysteresis: one stray outcome does not flip a strongly biased entry.

Top module: `bht_predictor`

## Requirements
- R1: The entry is selected by address bits [OFF_W +: IDX_W]. Bits above that slice are not compared, so two addresses that differ only there read and train the same counter.
- R2: The low OFF_W address bits (the word offset, 2 by default) do not affect which entry is selected.
- R3: An update with the outcome taken (upd_taken=1) adds one to the selected counter, and an update with the outcome not taken (upd_taken=0) subtracts one.
- R4: A counter at its maximum value 2^CTR_W-1 stays there on a taken update, and a counter at 0 stays at 0 on a not-taken update.
- R5: lkp_taken is 1 exactly when the counter read is at least 2^(CTR_W-1). With two bits, the values 2 and 3 predict taken and the values 0 and 1 predict not taken.
- R6: After reset every counter holds the weakly-not-taken value 2^(CTR_W-1)-1, which is 1 for two bits and 0 for one bit.
- R7: A lookup is combinational. When a lookup and an update select the same entry in the same cycle, the lookup returns the value held before the update, and the new value is visible from the next cycle.
- R8: Without upd_valid no counter changes. An update changes only the entry it selects.
- R9: With CTR_W=1 the counter equals the last outcome trained into the entry (1 taken, 0 not taken), and the prediction follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_addr | input | ADDR_W | Address of the branch being predicted |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_count | output | CTR_W | Counter value behind the prediction |
| upd_valid | input | 1 | Apply a training update this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Every cycle, the assertions check how a counter moves between two consecutive lookups of the same entry. They check the step up or down, the clamp at each end, the value held when there is no update or the update goes to another entry, and the reset value on the first cycle after reset. Aliasing through the upper address bits, the word offset having no effect, the old value returned when lookup and update collide, and the behaviour of the one-bit configuration are only shown by the bench. Its scenarios train chosen entries and compare each lookup against a model built from the requirements.

// File: rtl/bht_pkg.sv
package bht_pkg;

    // Step applied to one counter on a clock edge.
    typedef enum logic [1:0] {
        CTR_HOLD = 2'b00,
        CTR_INC  = 2'b01,
        CTR_DEC  = 2'b10
    } ctr_op_e;

    // Resolved branch outcome.
    typedef enum logic {
        OUT_NOT_TAKEN = 1'b0,
        OUT_TAKEN     = 1'b1
    } outcome_e;

    // Weakly-not-taken value for a counter of width w.
    function automatic int unsigned weak_not_taken(input int unsigned w);
        return (32'd1 << (w - 1)) - 32'd1;
    endfunction

    // Translate an update request into a counter step.
    function automatic ctr_op_e op_for(input logic hit, input outcome_e outc);
        if (!hit) begin
            return CTR_HOLD;
        end
        return (outc == OUT_TAKEN) ? CTR_INC : CTR_DEC;
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    // Drop the word offset, keep the next IDX_W bits, ignore the rest.
    assign idx = addr[OFF_W +: IDX_W];
endmodule

// File: rtl/bht_sat_ctr.sv
module bht_sat_ctr
    import bht_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_op_e          op,
    output logic [CTR_W-1:0] count
);
    localparam logic [CTR_W-1:0] CMAX  = '1;
    localparam logic [CTR_W-1:0] CMIN  = '0;
    localparam logic [CTR_W-1:0] CINIT = CTR_W'(weak_not_taken(CTR_W));

    logic [CTR_W-1:0] nxt;

    always_comb begin
        nxt = count;
        unique case (op)
            CTR_INC: if (count != CMAX) nxt = count + CTR_W'(1);
            CTR_DEC: if (count != CMIN) nxt = count - CTR_W'(1);
            default: nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CINIT;
        end else begin
            count <= nxt;
        end
    end
endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  outcome_e         wr_outc,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_count
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [CTR_W-1:0] cnt [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        ctr_op_e ent_op;
        assign ent_op = op_for(wr_en && (wr_idx == IDX_W'(e)), wr_outc);

        bht_sat_ctr #(.CTR_W(CTR_W)) u_ctr (
            .clk   (clk),
            .rst   (rst),
            .op    (ent_op),
            .count (cnt[e])
        );
    end

    // Read before write: a same-cycle update shows up after the edge.
    assign rd_count = cnt[rd_idx];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 6,
    parameter int CTR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] lkp_addr,
    output logic              lkp_taken,
    output logic [CTR_W-1:0]  lkp_count,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    outcome_e         outc;

    bht_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_rd_idx (
        .addr (lkp_addr),
        .idx  (rd_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_wr_idx (
        .addr (upd_addr),
        .idx  (wr_idx)
    );

    assign outc = upd_taken ? OUT_TAKEN : OUT_NOT_TAKEN;

    bht_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_outc  (outc),
        .rd_idx   (rd_idx),
        .rd_count (lkp_count)
    );

    // Upper half of the counter range predicts taken.
    assign lkp_taken = lkp_count[CTR_W-1];
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 6,
    parameter int CTR_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] lkp_addr,
    input logic [CTR_W-1:0]  lkp_count,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_addr,
    input logic              upd_taken
);
    localparam logic [CTR_W-1:0] CMAX  = '1;
    localparam logic [CTR_W-1:0] CINIT = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [IDX_W-1:0] li;
    logic [IDX_W-1:0] ui;
    assign li = lkp_addr[OFF_W +: IDX_W];
    assign ui = upd_addr[OFF_W +: IDX_W];

    AST_RESET_WEAK: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> lkp_count == CINIT); // R6

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid) && $past(upd_taken) && $past(ui) == $past(li) &&
         li == $past(li) && $past(lkp_count) != CMAX)
        |-> lkp_count == $past(lkp_count) + CTR_W'(1)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid) && !$past(upd_taken) && $past(ui) == $past(li) &&
         li == $past(li) && $past(lkp_count) != '0)
        |-> lkp_count == $past(lkp_count) - CTR_W'(1)); // R3

    AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid) && $past(upd_taken) && $past(ui) == $past(li) &&
         li == $past(li) && $past(lkp_count) == CMAX)
        |-> lkp_count == CMAX); // R4

    AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid) && !$past(upd_taken) && $past(ui) == $past(li) &&
         li == $past(li) && $past(lkp_count) == '0)
        |-> lkp_count == '0); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(upd_valid) && li == $past(li)) |-> $stable(lkp_count)); // R8

    AST_OTHER_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid) && $past(ui) != $past(li) && li == $past(li))
        |-> $stable(lkp_count)); // R8
endmodule

bind bht_predictor bht_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .CTR_W  (CTR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lkp_addr  (lkp_addr),
    .lkp_count (lkp_count),
    .upd_valid (upd_valid),
    .upd_addr  (upd_addr),
    .upd_taken (upd_taken)
);

// File: tb/bht_predictor_tb.sv
`timescale 1ns/1ps
module bht_predictor_tb;
    localparam int IDX_W = 6;
    localparam int OFF_W = 2;
    localparam int ENT   = 1 << IDX_W;

    typedef struct {
        int    c2;
        int    c1;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lkp_addr = '0;
    logic [31:0] upd_addr = '0;
    logic        upd_valid = 1'b0;
    logic        upd_taken = 1'b0;
    logic        tk2, tk1;
    logic [1:0]  cnt2;
    logic [0:0]  cnt1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int m2 [ENT];
    int m1 [ENT];
    exp_t q[$];

    always #2 clk = ~clk;

    bht_predictor #(.IDX_W(IDX_W), .CTR_W(2)) u_dut (
        .clk(clk), .rst(rst), .lkp_addr(lkp_addr), .lkp_taken(tk2),
        .lkp_count(cnt2), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_taken(upd_taken)
    );

    bht_predictor #(.IDX_W(IDX_W), .CTR_W(1)) u_dut1 (
        .clk(clk), .rst(rst), .lkp_addr(lkp_addr), .lkp_taken(tk1),
        .lkp_count(cnt1), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_taken(upd_taken)
    );

    function automatic int ix(input logic [31:0] a);
        return int'(a[OFF_W +: IDX_W]);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: drive one cycle, push the expected lookup result, advance the model.
    task automatic step(input logic [31:0] la, input logic uv,
                        input logic [31:0] ua, input logic ut, input string req);
        exp_t e;
        @(negedge clk);
        lkp_addr  = la;
        upd_valid = uv;
        upd_addr  = ua;
        upd_taken = ut;
        e.c2  = m2[ix(la)];
        e.c1  = m1[ix(la)];
        e.req = req;
        q.push_back(e);
        if (uv) begin
            if (ut) begin
                if (m2[ix(ua)] < 3) m2[ix(ua)]++;
                m1[ix(ua)] = 1;
            end else begin
                if (m2[ix(ua)] > 0) m2[ix(ua)]--;
                m1[ix(ua)] = 0;
            end
        end
    endtask

    // Monitor: pop and compare once the combinational lookup has settled.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, int'(cnt2), e.c2);
                check("R5", int'(tk2), (e.c2 >= 2) ? 1 : 0);
                check({e.req, "/R9"}, int'(cnt1), e.c1);
                check("R9", int'(tk1), e.c1);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < ENT; k++) begin
            m2[k] = 1;
            m1[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R6: reset value in several entries
        step(32'h0000_0000, 1'b0, 32'h0, 1'b0, "R6");
        step(32'h0000_0044, 1'b0, 32'h0, 1'b0, "R6");
        step(32'h0000_00FC, 1'b0, 32'h0, 1'b0, "R6");

        // R7: collision returns the old value, then the new one
        step(32'h20, 1'b1, 32'h20, 1'b1, "R7");
        step(32'h20, 1'b0, 32'h20, 1'b0, "R3");

        // R4: saturate high, then low
        for (int k = 0; k < 4; k++) step(32'h20, 1'b1, 32'h20, 1'b1, "R4");
        step(32'h20, 1'b0, 32'h0, 1'b0, "R4");
        for (int k = 0; k < 5; k++) step(32'h20, 1'b1, 32'h20, 1'b0, "R4");
        step(32'h20, 1'b0, 32'h0, 1'b0, "R4");

        // R1: aliasing through the upper address bits
        step(32'h130, 1'b1, 32'h30, 1'b1, "R1");
        step(32'h130, 1'b1, 32'h1030, 1'b1, "R1");
        step(32'h8000_0130, 1'b0, 32'h0, 1'b0, "R1");

        // R2: word offset bits ignored
        step(32'h33, 1'b1, 32'h31, 1'b0, "R2");
        step(32'h32, 1'b0, 32'h0, 1'b0, "R2");

        // R8: no effect without upd_valid, neighbours untouched
        step(32'h30, 1'b0, 32'h30, 1'b1, "R8");
        step(32'h30, 1'b0, 32'h30, 1'b0, "R8");
        step(32'h34, 1'b0, 32'h0, 1'b0, "R8");

        // R9: alternating outcomes on one entry
        for (int k = 0; k < 6; k++) step(32'h80, 1'b1, 32'h80, k[0], "R9");
        step(32'h80, 1'b0, 32'h0, 1'b0, "R9");

        // R3: mixed traffic
        for (int k = 0; k < 60; k++)
            step((k * 52) & 32'h3FF, 1'b1, (k * 28) & 32'hFF, (k % 3) != 0, "R3");

        step(32'h0, 1'b0, 32'h0, 1'b0, "R3");
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule